// File: doc/BRIEF.md
# Clock Output Gating Stage

This block sits between a set of internally generated clock waveforms and the device pins. For every output it decides whether the clock runs, is held low, or is not driven at all. Two inputs control the high-impedance state for all pins together: a global output-enable input and a two-bit register mode field. A software run bit per output, or per group of outputs, holds that clock low when cleared. A stop request, active low, silences the gated PCI clocks. The request is sampled on the rising edge of the free-running PCI clock.

The block runs on a fast system clock `clk_i`. It receives each clock waveform as a level that it samples on that clock. Any change to run/hold gating takes effect only while the affected waveform is low. As a result no output ever shows a shortened high phase. The drive-enable of every output is combinational, so a request for high impedance is never delayed.

Output layout of `clk_o`/`drv_o`: index 0 is the free-running PCI clock. The next `NUM_PCI` indices are the stoppable PCI clocks. Then come `SDR_GROUPS` groups of `SDR_PER_GROUP` copies of the SDRAM input, and the remaining `NUM_MISC` indices are the other fixed clocks.

Top module: `clk_out_gate`

## Requirements
- R1: While `oe_i` is 0, every bit of `drv_o` is 0.
- R2: While `mode_i` equals 2'b11, every bit of `drv_o` is 0. With `oe_i` at 1 and any other mode value (00, 01, 10), every bit of `drv_o` is 1.
- R3: `stop_ni` is sampled when `pci_f_i` is seen rising. If the sampled value is 0, the stoppable PCI outputs (indices 1..NUM_PCI) are held at 0 from the next `pci_f_i` high phase on, for as long as the sampled value stays 0. A sampled 1 lets them run again from the next high phase.
- R4: Output index 0 follows `pci_f_i` whatever `stop_ni` does.
- R5: A run bit of 0 holds its output at 0. A run bit of 1 lets the output copy its source waveform.
- R6: SDRAM run bit g gates all outputs from index 1+NUM_PCI+g*SDR_PER_GROUP through the following SDR_PER_GROUP-1 indices together.
- R7: Gating state changes only while the source waveform is low. An output rises only together with its source and falls only together with its source.
- R8: Priority: the drive state (R1, R2) applies whatever the run bits and stop state are. A cleared run bit holds an output low even while the stop state allows running. The stop state only affects outputs whose run bit is 1.
- R9: During and right after reset, every `clk_o` bit is 0 and the stop state is "run". Each output starts following its source at that source's first low phase after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pci_f_i | input | 1 | Free-running PCI clock waveform |
| pci_i | input | NUM_PCI | Stoppable PCI clock waveforms |
| sdr_i | input | 1 | SDRAM buffer input waveform |
| misc_i | input | NUM_MISC | Other fixed clock waveforms |
| pci_f_en_i | input | 1 | Run bit, free-running PCI output |
| pci_en_i | input | NUM_PCI | Run bits, stoppable PCI outputs |
| sdr_en_i | input | SDR_GROUPS | Run bits, one per SDRAM group |
| misc_en_i | input | NUM_MISC | Run bits, other outputs |
| stop_ni | input | 1 | PCI stop request, active low |
| oe_i | input | 1 | Global output enable |
| mode_i | input | 2 | Register mode field; 2'b11 forces high impedance |
| clk_o | output | NOUT | Gated clock values |
| drv_o | output | NOUT | Per-output drive enable |

## Verification
The bench builds the block with three stoppable PCI outputs, two SDRAM groups of three copies and two other clocks. This layout keeps group boundaries and index offsets distinct from the defaults, and every region of the output vector holds more than one bit. The free-running PCI clock has a period of four sampling cycles, the SDRAM input of two, and the other clocks six with offset phases. Stop and run-bit changes therefore land at every phase of each waveform, which brings truncated-pulse hazards and both stop sampling boundaries within reach.

// File: rtl/clk_out_gate_pkg.sv
package clk_out_gate_pkg;

  typedef enum logic [1:0] {
    MODE_NORM_A = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_NORM_B = 2'b10,
    MODE_HIZ    = 2'b11
  } out_mode_e;

  function automatic logic drive_ok(input logic oe, input logic [1:0] mode);
    return oe && (mode != MODE_HIZ);
  endfunction

endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic stop_ni,
  output logic run_o
);

  logic ref_q;
  logic run_q;
  logic ref_rise;

  assign ref_rise = ref_i && !ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b1;
      run_q <= 1'b1;
    end else begin
      ref_q <= ref_i;
      if (ref_rise) run_q <= stop_ni;
    end
  end

  assign run_o = run_q;

  // R3
  stop_on_ref_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q != $past(run_q)) |-> ($past(ref_i) && !$past(ref_i, 2) && (run_q == $past(stop_ni))));

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic want_i,
  output logic out_o
);

  logic run_q;

  // update only in the low phase of the source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (!src_i) run_q <= want_i;
  end

  assign out_o = src_i && run_q;

  // R7
  no_runt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o) |-> $rose(src_i));

  // R7
  no_runt_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_o) |-> $fell(src_i));

  // R5
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!want_i && !src_i) |=> !out_o);

endmodule

// File: rtl/clk_drive_ctl.sv
module clk_drive_ctl #(
  parameter int N = 4
) (
  input  logic         oe_i,
  input  logic [1:0]   mode_i,
  output logic [N-1:0] drv_o
);
  import clk_out_gate_pkg::*;

  assign drv_o = {N{drive_ok(oe_i, mode_i)}};

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int NUM_PCI       = 5,
  parameter int SDR_GROUPS    = 3,
  parameter int SDR_PER_GROUP = 4,
  parameter int NUM_MISC      = 4,
  localparam int SDR_BASE     = 1 + NUM_PCI,
  localparam int MISC_BASE    = SDR_BASE + SDR_GROUPS * SDR_PER_GROUP,
  localparam int NOUT         = MISC_BASE + NUM_MISC
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pci_f_i,
  input  logic [NUM_PCI-1:0]    pci_i,
  input  logic                  sdr_i,
  input  logic [NUM_MISC-1:0]   misc_i,
  input  logic                  pci_f_en_i,
  input  logic [NUM_PCI-1:0]    pci_en_i,
  input  logic [SDR_GROUPS-1:0] sdr_en_i,
  input  logic [NUM_MISC-1:0]   misc_en_i,
  input  logic                  stop_ni,
  input  logic                  oe_i,
  input  logic [1:0]            mode_i,
  output logic [NOUT-1:0]       clk_o,
  output logic [NOUT-1:0]       drv_o
);

  logic            pci_run;
  logic [NOUT-1:0] src;
  logic [NOUT-1:0] want;

  clk_stop_sync i_stop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (pci_f_i),
    .stop_ni (stop_ni),
    .run_o   (pci_run)
  );

  assign src[0]  = pci_f_i;
  assign want[0] = pci_f_en_i;

  for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci
    assign src[1+p]  = pci_i[p];
    assign want[1+p] = pci_en_i[p] && pci_run;
  end

  for (genvar g = 0; g < SDR_GROUPS; g++) begin : g_sdr
    for (genvar k = 0; k < SDR_PER_GROUP; k++) begin : g_copy
      assign src[SDR_BASE + g*SDR_PER_GROUP + k]  = sdr_i;
      assign want[SDR_BASE + g*SDR_PER_GROUP + k] = sdr_en_i[g];
    end
  end

  for (genvar m = 0; m < NUM_MISC; m++) begin : g_misc
    assign src[MISC_BASE+m]  = misc_i[m];
    assign want[MISC_BASE+m] = misc_en_i[m];
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_cell
    clk_gate_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src[i]),
      .want_i (want[i]),
      .out_o  (clk_o[i])
    );
  end

  clk_drive_ctl #(.N(NOUT)) i_drv (
    .oe_i   (oe_i),
    .mode_i (mode_i),
    .drv_o  (drv_o)
  );

  for (genvar g = 0; g < SDR_GROUPS; g++) begin : g_grp_chk
    // R6
    sdr_group_lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(clk_o[SDR_BASE + g*SDR_PER_GROUP +: SDR_PER_GROUP]) == 0) ||
      ($countones(clk_o[SDR_BASE + g*SDR_PER_GROUP +: SDR_PER_GROUP]) == SDR_PER_GROUP));
  end

endmodule

// File: tb/test_clk_out_gate.sv
module test_clk_out_gate;

  localparam int NP = 3;
  localparam int NG = 2;
  localparam int GS = 3;
  localparam int NM = 2;
  localparam int NO = 1 + NP + NG*GS + NM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          pf = 1'b0;
  logic [NP-1:0] pci = '0;
  logic          sdr = 1'b0;
  logic [NM-1:0] misc = '0;
  logic          pf_en = 1'b1;
  logic [NP-1:0] pci_en = '1;
  logic [NG-1:0] sdr_en = '1;
  logic [NM-1:0] misc_en = '1;
  logic          stop_n = 1'b1;
  logic          oe = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic [NO-1:0] out, drv;

  clk_out_gate #(
    .NUM_PCI(NP), .SDR_GROUPS(NG), .SDR_PER_GROUP(GS), .NUM_MISC(NM)
  ) i_clk_out_gate (
    .clk_i(clk), .rst_ni(rst_n), .pci_f_i(pf), .pci_i(pci), .sdr_i(sdr),
    .misc_i(misc), .pci_f_en_i(pf_en), .pci_en_i(pci_en), .sdr_en_i(sdr_en),
    .misc_en_i(misc_en), .stop_ni(stop_n), .oe_i(oe), .mode_i(mode),
    .clk_o(out), .drv_o(drv)
  );

  int vectors = 0;
  int errs = 0;
  int cyc = 0;
  string tag = "R9";
  int unsigned seed = 32'h1234_5678;

  // reference model state
  bit          m_prev_pf = 1'b1;
  bit          m_run = 1'b1;
  bit [NO-1:0] m_allow = '0;

  function automatic logic [NO-1:0] src_vec();
    logic [NO-1:0] v;
    v[0] = pf;
    for (int p = 0; p < NP; p++) v[1+p] = pci[p];
    for (int g = 0; g < NG; g++)
      for (int k = 0; k < GS; k++) v[1+NP+g*GS+k] = sdr;
    for (int m = 0; m < NM; m++) v[1+NP+NG*GS+m] = misc[m];
    return v;
  endfunction

  function automatic logic [NO-1:0] want_vec();
    logic [NO-1:0] v;
    v[0] = pf_en;
    for (int p = 0; p < NP; p++) v[1+p] = pci_en[p] & m_run;
    for (int g = 0; g < NG; g++)
      for (int k = 0; k < GS; k++) v[1+NP+g*GS+k] = sdr_en[g];
    for (int m = 0; m < NM; m++) v[1+NP+NG*GS+m] = misc_en[m];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_pf = 1'b1;
      m_run     = 1'b1;
      m_allow   = '0;
    end else begin
      logic [NO-1:0] w, s;
      w = want_vec();
      s = src_vec();
      for (int i = 0; i < NO; i++) if (!s[i]) m_allow[i] = w[i];
      if (pf && !m_prev_pf) m_run = stop_n;
      m_prev_pf = pf;
    end
  end

  task automatic check();
    logic [NO-1:0] e_out, e_drv;
    e_out = src_vec() & m_allow;
    e_drv = (oe && mode != 2'b11) ? '1 : '0;
    vectors++;
    if (out !== e_out || drv !== e_drv) begin
      errs++;
      $display("FAIL %s cyc=%0d clk_o=%b exp=%b drv_o=%b exp=%b",
               tag, cyc, out, e_out, drv, e_drv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      check();
      cyc++;
      pf      = (cyc % 4) < 2;
      pci     = {NP{pf}};
      sdr     = cyc[0];
      misc[0] = (cyc % 6) < 3;
      misc[1] = ((cyc + 2) % 6) < 3;
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  initial begin
    // R9: reset state, then release
    tag = "R9";
    step(4);
    rst_n = 1'b1;
    step(8);

    // R5: all running
    tag = "R5";
    step(16);
    pci_en = 3'b010; step(5);
    misc_en = 2'b01; step(7);
    pf_en = 1'b0; step(9);
    pf_en = 1'b1; pci_en = '1; misc_en = '1; step(10);

    // R6: group run bits
    tag = "R6";
    sdr_en = 2'b01; step(7);
    sdr_en = 2'b10; step(6);
    sdr_en = 2'b00; step(5);
    sdr_en = 2'b11; step(6);

    // R3: stop request at each phase of the free-running clock
    tag = "R3";
    for (int ph = 0; ph < 4; ph++) begin
      step(ph + 1);
      stop_n = 1'b0; step(13);
      stop_n = 1'b1; step(11);
    end
    // pulse shorter than one PCI period, may be missed
    stop_n = 1'b0; step(1);
    stop_n = 1'b1; step(9);

    // R4: free-running output ignores stop
    tag = "R4";
    stop_n = 1'b0; step(20);
    pf_en = 1'b0; step(6);
    pf_en = 1'b1; step(10);
    stop_n = 1'b1; step(8);

    // R8: priority between drive, run bits and stop
    tag = "R8";
    stop_n = 1'b1; pci_en = 3'b000; step(10);
    stop_n = 1'b0; pci_en = 3'b101; step(12);
    mode = 2'b11; step(8);
    oe = 1'b0; mode = 2'b00; step(6);
    oe = 1'b1; stop_n = 1'b1; pci_en = '1; step(10);

    // R1: global output enable
    tag = "R1";
    oe = 1'b0; step(9);
    oe = 1'b1; step(3);

    // R2: mode field
    tag = "R2";
    for (int md = 0; md < 4; md++) begin
      mode = md[1:0]; step(7);
    end
    mode = 2'b00; step(3);

    // R7: random control activity
    tag = "R7";
    for (int n = 0; n < 300; n++) begin
      int unsigned r;
      r = rnd();
      pf_en   = r[0] | r[1];
      pci_en  = r[4:2] | r[7:5];
      sdr_en  = r[9:8] | r[11:10];
      misc_en = r[13:12] | r[15:14];
      stop_n  = r[16] | r[17];
      oe      = r[18] | r[19] | r[20];
      mode    = (r[23:21] == 3'd0) ? 2'b11 : {1'b0, r[24]};
      step(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule